// File: doc/BRIEF.md
# Overlay Window Fetch Address and Burst Generator

This block serves one overlay window of a display pipeline. It holds the window's on-screen rectangle and the layout of the window's image in memory. It also holds the pixel format, which sets the bytes per pixel and the burst size. From these it does two things. First, it tells the scan-out logic whether the current screen position lies inside the window. Second, it issues a stream of memory read requests that walk the window's image one line at a time. Each line is cut into bursts, and the block skips the unused part of the framebuffer between lines. It stops when the frame's end address is reached.

Configuration inputs are sampled only on a vertical sync pulse, and the whole frame is then fetched with that configuration. Software or an upstream controller can therefore rewrite the inputs at any time without disturbing a frame that is in progress. Requests use a valid/ready handshake in which each request carries a byte address and a byte length. The memory bus protocol, pixel unpacking and blending belong to neighbouring blocks.

Top module: `ovl_win_fetch`

## Requirements
- R1: After reset, `req_valid` is 0, `frame_done` is 1 and `in_window` is 0. No request and no inside indication appears before the first `vsync`.
- R2: `in_window` is registered and is due one cycle after the scan position. It is 1 when x0 <= scan_x <= x1 and y0 <= scan_y <= y1. Here x1 = x0 + width - 1 and y1 = y0 + height - 1, and each is clamped to 0 when x0 + width (or y0 + height) is 0.
- R3: Format code 0 is 1 byte per pixel. Codes 1 and 2 are 2 bytes per pixel. Code 4 is 4 bytes per pixel. Code 3 and every other code (5, 6, 7) use 4 bytes per pixel. The line byte width is the window width times bytes per pixel.
- R4: The burst size is 8 words of 4 bytes for code 0 and 16 words for all other codes. It is forced to 4 words when the framebuffer width is below 128 pixels. `req_len` is the lesser of the burst size in bytes and the bytes still left in the current line, so the last burst of a line is shortened.
- R5: Within a line, each accepted request is followed by one whose address is the previous address plus the previous length.
- R6: After the last burst of a line, the next line starts at the old line start plus the line byte width plus the line skip. The line skip is (framebuffer width - window width) times bytes per pixel.
- R7: The end address is base + framebuffer width × window height × bytes per pixel. When the next line start reaches or passes it, `frame_done` rises and `req_valid` falls until the next `vsync`. A frame with zero line bytes or zero frame bytes is done immediately after `vsync`.
- R8: On `vsync` every configuration input is captured and fetching restarts at the base address. Changes to the configuration between pulses have no effect on the frame in progress.
- R9: A `vsync` in the same cycle as an accepted request takes priority, and the frame restarts.
- R10: While `req_valid` is 1 and `req_ready` is 0, the request's address and length hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Frame start pulse; captures configuration |
| cfg_x0 | input | COORD_W | Window left column |
| cfg_y0 | input | COORD_W | Window top row |
| cfg_width | input | COORD_W | Window width in pixels |
| cfg_height | input | COORD_W | Window height in lines |
| cfg_fb_width | input | COORD_W | Framebuffer width in pixels |
| cfg_base | input | ADDR_W | Byte address of the window's first pixel |
| cfg_fmt | input | 3 | Pixel format code |
| scan_x | input | COORD_W | Current scan column |
| scan_y | input | COORD_W | Current scan row |
| in_window | output | 1 | Scan position was inside the window (one cycle late) |
| req_valid | output | 1 | Burst request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Burst byte address |
| req_len | output | 7 | Burst length in bytes |
| frame_done | output | 1 | Frame fetch complete |

## Verification
The request outputs come straight from registers. A `vsync` or an accepted request sampled at one rising edge is reflected in `req_valid`, `req_addr`, `req_len` and `frame_done` after that same edge. `in_window` has one register stage, so it reflects the scan position sampled at the previous edge, compared against the rectangle captured before that edge. The bench drives inputs shortly after the rising edge. It updates a behavioural model at the rising edge and compares all outputs at the falling edge, which lands every comparison in the cycle where the result is due.

// File: rtl/ovl_win_pkg.sv
package ovl_win_pkg;

  typedef enum logic [2:0] {
    FMT_PAL8     = 3'd0,
    FMT_RGB1555  = 3'd1,
    FMT_RGB565   = 3'd2,
    FMT_RGB888   = 3'd3,
    FMT_ARGB8888 = 3'd4
  } pix_fmt_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/ovl_win_fmt.sv
module ovl_win_fmt
  import ovl_win_pkg::*;
#(
  parameter int unsigned COORD_W      = 12,
  parameter int unsigned SMALL_FB_W   = 128,
  parameter int unsigned BURST_PAL    = 8,
  parameter int unsigned BURST_WIDE   = 16,
  parameter int unsigned BURST_NARROW = 4,
  parameter int unsigned LEN_W        = 7
) (
  input  logic [2:0]         fmt_code,
  input  logic [COORD_W-1:0] fb_width,
  output logic [2:0]         bytes_pp,
  output logic [LEN_W-1:0]   burst_bytes
);

  logic [LEN_W-1:0] words;

  // Format decode: unknown codes fall back to unpacked 24-bit in a word
  always_comb begin
    unique case (pix_fmt_e'(fmt_code))
      FMT_PAL8: begin
        bytes_pp = 3'd1;
        words    = LEN_W'(BURST_PAL);
      end
      FMT_RGB1555, FMT_RGB565: begin
        bytes_pp = 3'd2;
        words    = LEN_W'(BURST_WIDE);
      end
      FMT_RGB888, FMT_ARGB8888: begin
        bytes_pp = 3'd4;
        words    = LEN_W'(BURST_WIDE);
      end
      default: begin
        bytes_pp = 3'd4;
        words    = LEN_W'(BURST_WIDE);
      end
    endcase
    if (fb_width < COORD_W'(SMALL_FB_W)) begin
      words = LEN_W'(BURST_NARROW);
    end
    burst_bytes = LEN_W'(words * LEN_W'(WORD_BYTES));
  end

endmodule

// File: rtl/ovl_win_geom.sv
module ovl_win_geom #(
  parameter int unsigned COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic [COORD_W-1:0] cfg_x0,
  input  logic [COORD_W-1:0] cfg_y0,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [COORD_W-1:0] scan_x,
  input  logic [COORD_W-1:0] scan_y,
  output logic               in_window
);

  localparam int unsigned EXT_W  = COORD_W + 1;
  localparam int unsigned N_AXIS = 2;

  logic [N_AXIS-1:0][COORD_W-1:0] org;
  logic [N_AXIS-1:0][COORD_W-1:0] size;
  logic [N_AXIS-1:0][COORD_W-1:0] pos;
  logic [N_AXIS-1:0]              axis_hit;

  assign org  = {cfg_y0, cfg_x0};
  assign size = {cfg_height, cfg_width};
  assign pos  = {scan_y, scan_x};

  // One inclusive interval per axis, captured at vsync
  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    logic [EXT_W-1:0] lo_q, lo_d, hi_q, hi_d, span;

    assign span = {1'b0, org[a]} + {1'b0, size[a]};

    always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (vsync) begin
        lo_d = {1'b0, org[a]};
        hi_d = (span == '0) ? '0 : span - EXT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign axis_hit[a] = ({1'b0, pos[a]} >= lo_q) && ({1'b0, pos[a]} <= hi_q);
  end

  logic armed_q, armed_d;
  logic hit_q, hit_d;

  always_comb begin
    armed_d = armed_q | vsync;
    hit_d   = armed_q & (&axis_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      hit_q   <= hit_d;
    end
  end

  assign in_window = hit_q;

endmodule

// File: rtl/ovl_win_addr.sv
module ovl_win_addr #(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [COORD_W-1:0] cfg_fb_width,
  input  logic [2:0]         bytes_pp,
  input  logic [LEN_W-1:0]   burst_bytes,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  output logic               frame_done
);

  localparam int unsigned LB_W = COORD_W + 3;

  // Shadow configuration and walk state
  logic [LB_W-1:0]   lb_q, lb_d, skip_q, skip_d, off_q, off_d;
  logic [ADDR_W-1:0] line_q, line_d, end_q, end_d;
  logic [LEN_W-1:0]  burst_q, burst_d;
  logic              done_q, done_d;

  // Values derived from the live configuration (used only at vsync)
  logic [LB_W-1:0]   w_ext, fb_ext, bpp_ext, new_lb, new_skip, pitch;
  logic [ADDR_W-1:0] frame_bytes, new_end;

  assign w_ext       = LB_W'(cfg_width);
  assign fb_ext      = LB_W'(cfg_fb_width);
  assign bpp_ext     = LB_W'(bytes_pp);
  assign new_lb      = w_ext * bpp_ext;
  assign new_skip    = (fb_ext - w_ext) * bpp_ext;
  assign pitch       = fb_ext * bpp_ext;
  assign frame_bytes = ADDR_W'(pitch) * ADDR_W'(cfg_height);
  assign new_end     = cfg_base + frame_bytes;

  // Burst slicing of the current line
  logic [LB_W-1:0]   remain, burst_ext, len_full;
  logic [ADDR_W-1:0] next_line;
  logic              line_last, fire;

  assign remain    = lb_q - off_q;
  assign burst_ext = LB_W'(burst_q);
  assign line_last = (remain <= burst_ext);
  assign len_full  = line_last ? remain : burst_ext;
  assign next_line = line_q + ADDR_W'(lb_q) + ADDR_W'(skip_q);

  assign req_valid  = ~done_q;
  assign req_addr   = line_q + ADDR_W'(off_q);
  assign req_len    = LEN_W'(len_full);
  assign frame_done = done_q;
  assign fire       = req_valid & req_ready;

  always_comb begin
    lb_d    = lb_q;
    skip_d  = skip_q;
    end_d   = end_q;
    burst_d = burst_q;
    line_d  = line_q;
    off_d   = off_q;
    done_d  = done_q;
    if (vsync) begin
      lb_d    = new_lb;
      skip_d  = new_skip;
      end_d   = new_end;
      burst_d = burst_bytes;
      line_d  = cfg_base;
      off_d   = '0;
      done_d  = (new_lb == '0) || (frame_bytes == '0);
    end else if (fire) begin
      if (line_last) begin
        off_d  = '0;
        line_d = next_line;
        done_d = (next_line >= end_q);
      end else begin
        off_d  = off_q + len_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q    <= '0;
      skip_q  <= '0;
      end_q   <= '0;
      burst_q <= '0;
      line_q  <= '0;
      off_q   <= '0;
      done_q  <= 1'b1;
    end else begin
      lb_q    <= lb_d;
      skip_q  <= skip_d;
      end_q   <= end_d;
      burst_q <= burst_d;
      line_q  <= line_d;
      off_q   <= off_d;
      done_q  <= done_d;
    end
  end

  // R10: a stalled request keeps its address and length
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !vsync) |=>
      (req_valid && $stable(req_addr) && $stable(req_len)));

  // R4: a pending request never asks for nothing nor more than one burst
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= burst_q));

  // R5: bursts inside a line are contiguous
  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !vsync && !line_last) |=>
      (req_addr == $past(req_addr) + ADDR_W'($past(req_len))));

  // R7: once done, the frame stays done until the next vsync
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !vsync) |=> frame_done);

  // R8: vsync restarts the walk at the captured base address
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (frame_done || (req_addr == $past(cfg_base))));

endmodule

// File: rtl/ovl_win_fetch.sv
module ovl_win_fetch #(
  parameter int unsigned COORD_W      = 12,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SMALL_FB_W   = 128,
  parameter int unsigned BURST_PAL    = 8,
  parameter int unsigned BURST_WIDE   = 16,
  parameter int unsigned BURST_NARROW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic [COORD_W-1:0] cfg_x0,
  input  logic [COORD_W-1:0] cfg_y0,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [COORD_W-1:0] cfg_fb_width,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [2:0]         cfg_fmt,
  input  logic [COORD_W-1:0] scan_x,
  input  logic [COORD_W-1:0] scan_y,
  output logic               in_window,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [6:0]         req_len,
  output logic               frame_done
);

  localparam int unsigned LEN_W = 7;

  logic [2:0]       bytes_pp;
  logic [LEN_W-1:0] burst_bytes;

  ovl_win_fmt #(
    .COORD_W     (COORD_W),
    .SMALL_FB_W  (SMALL_FB_W),
    .BURST_PAL   (BURST_PAL),
    .BURST_WIDE  (BURST_WIDE),
    .BURST_NARROW(BURST_NARROW),
    .LEN_W       (LEN_W)
  ) u_fmt (
    .fmt_code   (cfg_fmt),
    .fb_width   (cfg_fb_width),
    .bytes_pp   (bytes_pp),
    .burst_bytes(burst_bytes)
  );

  ovl_win_geom #(
    .COORD_W(COORD_W)
  ) u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .cfg_x0    (cfg_x0),
    .cfg_y0    (cfg_y0),
    .cfg_width (cfg_width),
    .cfg_height(cfg_height),
    .scan_x    (scan_x),
    .scan_y    (scan_y),
    .in_window (in_window)
  );

  ovl_win_addr #(
    .COORD_W(COORD_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync       (vsync),
    .cfg_base    (cfg_base),
    .cfg_width   (cfg_width),
    .cfg_height  (cfg_height),
    .cfg_fb_width(cfg_fb_width),
    .bytes_pp    (bytes_pp),
    .burst_bytes (burst_bytes),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .frame_done  (frame_done)
  );

endmodule

// File: tb/test_ovl_win_fetch.sv
module test_ovl_win_fetch;

  localparam int CW = 12;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vsync = 1'b0;
  logic [CW-1:0] cfg_x0 = '0, cfg_y0 = '0, cfg_width = '0, cfg_height = '0;
  logic [CW-1:0] cfg_fb_width = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [2:0]    cfg_fmt = '0;
  logic [CW-1:0] scan_x = '0, scan_y = '0;
  logic          req_ready = 1'b0;
  logic          in_window, req_valid, frame_done;
  logic [AW-1:0] req_addr;
  logic [6:0]    req_len;

  always #10 clk = ~clk;

  ovl_win_fetch i_ovl_win_fetch (
    .clk(clk), .rst_n(rst_n), .vsync(vsync),
    .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_fb_width(cfg_fb_width),
    .cfg_base(cfg_base), .cfg_fmt(cfg_fmt),
    .scan_x(scan_x), .scan_y(scan_y), .in_window(in_window),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .frame_done(frame_done)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string phase = "R1 reset";
  int    ready_mode = 0;
  int    cyc = 0;

  // Behavioural reference state
  bit     m_done = 1, m_armed = 0, m_inwin = 0;
  longint m_x0 = 0, m_x1 = 0, m_y0 = 0, m_y1 = 0;
  longint m_lb = 0, m_skip = 0, m_end = 0, m_burst = 0, m_line = 0, m_off = 0;
  longint t_rem, t_len, t_bpp, t_span;
  longint e_rem, e_len;

  function automatic longint f_bpp(input int code);
    if (code == 0) return 1;
    if (code == 1 || code == 2) return 2;
    return 4;
  endfunction

  function automatic longint f_burst(input int code, input int fbw);
    if (fbw < 128) return 16;
    if (code == 0) return 32;
    return 64;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 1; m_armed = 0; m_inwin = 0;
      m_x0 = 0; m_x1 = 0; m_y0 = 0; m_y1 = 0;
      m_lb = 0; m_skip = 0; m_end = 0; m_burst = 0; m_line = 0; m_off = 0;
    end else begin
      m_inwin = m_armed && scan_x >= m_x0 && scan_x <= m_x1 &&
                scan_y >= m_y0 && scan_y <= m_y1;
      t_rem = m_lb - m_off;
      t_len = (t_rem < m_burst) ? t_rem : m_burst;
      if (vsync) begin
        m_armed = 1;
        m_x0 = cfg_x0;
        t_span = longint'(cfg_x0) + cfg_width;
        m_x1 = (t_span == 0) ? 0 : t_span - 1;
        m_y0 = cfg_y0;
        t_span = longint'(cfg_y0) + cfg_height;
        m_y1 = (t_span == 0) ? 0 : t_span - 1;
        t_bpp   = f_bpp(cfg_fmt);
        m_lb    = cfg_width * t_bpp;
        m_skip  = (longint'(cfg_fb_width) - cfg_width) * t_bpp;
        m_end   = cfg_base + longint'(cfg_fb_width) * cfg_height * t_bpp;
        m_burst = f_burst(cfg_fmt, cfg_fb_width);
        m_line  = cfg_base;
        m_off   = 0;
        m_done  = (m_lb == 0) || (m_end == cfg_base);
      end else if (!m_done && req_ready) begin
        if (m_off + t_len == m_lb) begin
          m_line = m_line + m_lb + m_skip;
          m_off  = 0;
          m_done = (m_line >= m_end);
        end else begin
          m_off = m_off + t_len;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s]: actual %0d expected %0d", what, phase, act, exp);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_window == m_inwin, "R2 in_window", in_window, m_inwin);
      chk(req_valid == !m_done, "R7 req_valid", req_valid, !m_done);
      chk(frame_done == m_done, "R7 frame_done", frame_done, m_done);
      if (!m_done) begin
        e_rem = m_lb - m_off;
        e_len = (e_rem < m_burst) ? e_rem : m_burst;
        if (m_off == 0)
          chk(req_addr == AW'(m_line), "R6 line start address", req_addr, m_line);
        else
          chk(req_addr == AW'(m_line + m_off), "R5 burst address", req_addr, m_line + m_off);
        chk(req_len == 7'(e_len), "R3/R4 burst length", req_len, e_len);
      end
    end
  end

  task automatic step(input bit v);
    @(posedge clk);
    #2;
    vsync = v;
    cyc++;
    if (scan_x == 39) begin
      scan_x = '0;
      scan_y = (scan_y == 9) ? '0 : scan_y + 1'b1;
    end else begin
      scan_x = scan_x + 1'b1;
    end
    req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  endtask

  task automatic set_cfg(input int x0, input int y0, input int w, input int h,
                         input int fb, input longint base, input int fmt);
    cfg_x0 = CW'(x0); cfg_y0 = CW'(y0); cfg_width = CW'(w); cfg_height = CW'(h);
    cfg_fb_width = CW'(fb); cfg_base = AW'(base); cfg_fmt = 3'(fmt);
  endtask

  task automatic frame(input string ph, input int x0, input int y0, input int w,
                       input int h, input int fb, input longint base, input int fmt,
                       input int rmode, input int ncyc);
    phase = ph;
    ready_mode = rmode;
    @(posedge clk);
    #1;
    set_cfg(x0, y0, w, h, fb, base, fmt);
    step(1'b1);
    for (int i = 0; i < ncyc; i++) step(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(req_valid == 1'b0, "R1 req_valid in reset", req_valid, 0);
    chk(frame_done == 1'b1, "R1 frame_done in reset", frame_done, 1);
    chk(in_window == 1'b0, "R1 in_window in reset", in_window, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R1: no activity before the first vsync, scan sweeping (0,0) region
    phase = "R1 idle before vsync";
    set_cfg(0, 0, 40, 10, 200, 'h100, 3);
    for (int i = 0; i < 60; i++) step(1'b0);

    // R2 R6: 16-bit format, one burst per line, line skip applied
    frame("R6 rgb565 line walk", 10, 5, 20, 3, 200, 'h1000, 2, 0, 420);
    // R3 R4: palette format, 32-byte bursts with a short tail, stalls (R10)
    frame("R10 pal8 stalled bursts", 3, 2, 100, 2, 300, 'h2001, 0, 1, 60);
    // R4: narrow framebuffer forces 4-word bursts
    frame("R4 narrow fb argb", 30, 8, 10, 4, 100, 'h3000, 4, 0, 40);
    // R3: unknown code falls back to 4 bytes per pixel
    frame("R3 unknown format", 0, 0, 30, 3, 160, 'h4000, 7, 1, 60);
    // R3: 1555 format
    frame("R3 rgb1555 format", 5, 5, 50, 2, 140, 'h5002, 1, 0, 30);
    // R7: empty window done at once; R2 clamp puts (0,0) inside
    frame("R7 R2 empty window clamp", 0, 0, 0, 0, 200, 'h6000, 3, 0, 410);
    // R7: zero height with nonzero width
    frame("R7 zero height", 4, 4, 8, 0, 200, 'h6100, 2, 0, 8);

    // R8: configuration changes mid-frame are ignored until vsync
    frame("R8 config held until vsync", 2, 1, 24, 4, 130, 'h7000, 3, 1, 10);
    set_cfg(20, 6, 3, 1, 50, 'h9990, 0);
    for (int i = 0; i < 80; i++) step(1'b0);
    phase = "R8 new config after vsync";
    step(1'b1);
    for (int i = 0; i < 40; i++) step(1'b0);

    // R9: vsync while a request is being accepted restarts the frame
    frame("R9 vsync during accept", 1, 1, 60, 6, 200, 'h8000, 4, 0, 5);
    chk(req_valid == 1'b1, "R9 request active before restart", req_valid, 1);
    frame("R9 vsync during accept", 1, 1, 60, 6, 200, 'h8800, 4, 0, 60);

    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired [%s]: actual 0 expected 1", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule